// File: doc/BRIEF.md
# Transmit Self-Test Enable Latch and Pattern Generator

This block sits on the transmit side of a multi-channel serial link. Each channel has a self-test enable. When a channel's self-test is on, the block drives a pseudo-random 10-bit character stream onto that channel in place of the user's characters. The far end can then check the link against an identical generator.

The enable bits arrive active-low on a shared vector. They are taken in while a capture strobe is high and are held while it is low. A device reset clears every enable. The enable store is a register on the character clock rather than a true latch. With the strobe high it follows the inverted vector one cycle later.

While a channel is enabled, its 9-bit generator advances once per character clock and never reaches the all-zero state. It is reloaded with all ones whenever the channel is disabled, so every enable starts the same 511-character cycle from the same place.

Top module: `tx_selftest_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every channel's enable is cleared, so from the following cycle `tx_char` equals `user_data` on all channels. Reset takes priority over `latch_en`.
- R2: When `latch_en` is high at a rising edge, channel i becomes enabled from the next cycle if `test_en_n[i]` was low, and disabled if it was high.
- R3: When `latch_en` is low at a rising edge, no channel's enable changes, whatever `test_en_n` holds.
- R4: A disabled channel passes its user character through unchanged and without delay: `tx_char[10i+9:10i]` equals `user_data[10i+9:10i]`.
- R5: An enabled channel ignores its `user_data` slice completely.
- R6: In the first cycle after a channel becomes enabled, its character is 10'h3FF (generator state all ones, parity bit 1).
- R7: An enabled channel's character is {p, s}. Here s is the 9-bit generator state, which sits in bits [8:0], and p is bit 9, the XOR of the nine bits of s. Each clock the state moves from s to {s[7:0], s[8]^s[4]}, following the polynomial x^9 + x^5 + 1.
- R8: The enabled sequence repeats with a period of exactly 511 characters, and the state is never all zero.
- R9: Disabling and then re-enabling a channel, or a reset, restarts its sequence at 10'h3FF.
- R10: Channels are independent: the enable and the sequence of one channel do not affect any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Device reset, active low, sampled on the clock |
| latch_en | input | 1 | Enable capture strobe; capture while high, hold while low |
| test_en_n | input | NCH | Per-channel self-test enable, active low |
| user_data | input | NCH*CW | User characters, channel i in bits [CW*i+CW-1:CW*i] |
| tx_char | output | NCH*CW | Characters to the serializer, same channel layout |

## Verification
Pass-through is tried with several user data patterns on every channel. These separate a correct direct path from a registered or cross-wired one. The generator is compared character by character against a model for more than one full period. This catches a wrong tap, shift direction, seed or parity bit, and the point of the first repeat confirms the 511 period. User data is changed while the generator runs, and `test_en_n` is changed with the strobe low; these show the ignore and hold behaviour. Disable, re-enable and reset in the middle of a sequence show that the seed is reloaded and that reset takes priority.

// File: rtl/tx_selftest_gen.sv
module tx_selftest_gen #(
  parameter int NCH = 4,
  parameter int CW  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            latch_en,
  input  logic [NCH-1:0]  test_en_n,
  input  logic [NCH*CW-1:0] user_data,
  output logic [NCH*CW-1:0] tx_char
);

  localparam int SW = CW - 1;

  logic [NCH-1:0]         en_q;
  logic [NCH-1:0][SW-1:0] lfsr;

  always_ff @(posedge clk) begin
    if (!rst_n)        en_q <= '0;
    else if (latch_en) en_q <= ~test_en_n;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n || !en_q[i]) lfsr[i] <= '1;
      else                    lfsr[i] <= {lfsr[i][SW-2:0], lfsr[i][8] ^ lfsr[i][4]};
    end

    assign tx_char[CW*i +: CW] = en_q[i] ? {^lfsr[i], lfsr[i]} : user_data[CW*i +: CW];
  end

endmodule

// File: rtl/tx_selftest_gen_chk.sv
module tx_selftest_gen_chk #(
  parameter int NCH = 4,
  parameter int CW  = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   latch_en,
  input logic [NCH-1:0]         test_en_n,
  input logic [NCH-1:0]         en_q,
  input logic [NCH-1:0][CW-2:0] lfsr,
  input logic [NCH*CW-1:0]      tx_char
);

  a_r3_hold_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> $stable(en_q));

  a_r2_capture_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |=> en_q == ~$past(test_en_n));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    a_r8_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      en_q[i] |-> lfsr[i] != '0);

    a_r6_seed_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q[i]) |-> tx_char[CW*i +: CW] == '1);

    a_r7_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
      en_q[i] |-> ^tx_char[CW*i +: CW] == 1'b0);
  end

endmodule

bind tx_selftest_gen tx_selftest_gen_chk #(.NCH(NCH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .test_en_n(test_en_n),
  .en_q(en_q), .lfsr(lfsr), .tx_char(tx_char)
);

// File: tb/tx_selftest_gen_tb_top.sv
module tx_selftest_gen_tb_top;
  localparam int NCH = 4;
  localparam int CW  = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic latch_en = 0;
  logic [NCH-1:0] test_en_n = '1;
  logic [NCH*CW-1:0] user_data = '0;
  logic [NCH*CW-1:0] tx_char;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tx_selftest_gen #(.NCH(NCH), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .test_en_n(test_en_n),
    .user_data(user_data), .tx_char(tx_char)
  );

  function automatic logic [8:0] nxt(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction

  function automatic logic [9:0] chr(input logic [8:0] s);
    return {^s, s};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [9:0] got, input logic [9:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [9:0] ch(input int i);
    return tx_char[CW*i +: CW];
  endfunction

  task automatic t_reset();
    rst_n = 0; latch_en = 1; test_en_n = '0;
    user_data = 40'h12_3456_789A;
    tick(); tick();
    #1;
    for (int i = 0; i < NCH; i++) chk("R1 reset passthrough", ch(i), user_data[CW*i +: CW]);
    rst_n = 1; latch_en = 0; test_en_n = '1;
    tick();
  endtask

  task automatic t_passthru();
    logic [39:0] pats [3] = '{40'h00_0000_0000, 40'hFF_FFFF_FFFF, 40'hA5_5A3C_C3E1};
    for (int p = 0; p < 3; p++) begin
      user_data = pats[p];
      #1;
      for (int i = 0; i < NCH; i++) chk("R4 passthrough", ch(i), pats[p][CW*i +: CW]);
    end
  endtask

  task automatic t_sequence();
    logic [8:0] s = 9'h1FF;
    int first_rep = 0;
    latch_en = 1; test_en_n = 4'b1110;
    tick();
    latch_en = 0;
    chk("R6 seed char", ch(0), 10'h3FF);
    for (int n = 1; n <= 515; n++) begin
      tick();
      s = nxt(s);
      user_data = {n[7:0], n[15:0], n[15:0]} ^ 40'h5A_A5F0_0F33;
      #1;
      if (n <= 520 && ch(0) !== chr(s)) chk("R7 sequence", ch(0), chr(s));
      else n_chk++;
      if (ch(0)[8:0] == 9'h000) chk("R8 nonzero", ch(0), 10'h3FF);
      if (first_rep == 0 && ch(0) == 10'h3FF) first_rep = n;
      for (int i = 1; i < NCH; i++)
        if (n % 128 == 0) chk("R10 other channel passthrough", ch(i), user_data[CW*i +: CW]);
      if (n == 300) chk("R5 user data ignored", ch(0), chr(s));
    end
    chk("R8 period 511", 10'(first_rep), 10'd511);
  endtask

  task automatic t_hold();
    logic [8:0] s;
    latch_en = 0; test_en_n = 4'b0000;
    tick(); tick();
    user_data = 40'h11_2233_4455;
    #1;
    for (int i = 1; i < NCH; i++) chk("R3 hold closed", ch(i), user_data[CW*i +: CW]);
    chk("R3 hold keeps ch0 on", {9'd0, ch(0) != user_data[9:0]}, 10'd1);
    latch_en = 1; test_en_n = 4'b0111;
    tick();
    latch_en = 0;
    chk("R2 ch3 on seeds", ch(3), 10'h3FF);
    chk("R2 ch0 off passthrough", ch(0), user_data[9:0]);
    s = 9'h1FF;
    for (int n = 0; n < 5; n++) begin tick(); s = nxt(s); end
    chk("R10 ch3 independent sequence", ch(3), chr(s));
    latch_en = 1; test_en_n = 4'b1111;
    tick();
    latch_en = 1; test_en_n = 4'b0111;
    tick();
    latch_en = 0;
    chk("R9 re-enable restarts", ch(3), 10'h3FF);
    tick(); tick();
    rst_n = 0; tick();
    chk("R1 reset clears enable", ch(3), user_data[39:30]);
    rst_n = 1; latch_en = 1; tick(); latch_en = 0;
    chk("R9 after reset restarts", ch(3), 10'h3FF);
  endtask

  initial begin
    t_reset();
    t_passthru();
    t_sequence();
    t_hold();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule